// File: doc/BRIEF.md
# PWM break override controller

This block drives four pulse-width modulated outputs from one shared 12-bit free-running up-counter. Each channel compares the counter with its own duty value, so the output is high for the first part of each 4096-cycle period. The duty value is double-buffered. A new value written by software takes effect only when the counter wraps, so a period never ends up with mixed widths.

An emergency stop path watches one of two asynchronous inputs: an external stop pin or the digital output of an analog comparator. Each input passes through a synchronizer. Software selects which input is watched and which level counts as a fault. When detection is enabled and the watched input sits at its fault level, a sticky stop flag is set. While the flag is set, every enabled channel stops modulating and holds a fixed level taken from a software-written pattern. The flag stays set until software writes it back to zero. Software may also set the flag directly.

All configuration goes through a small register port. Writes are synchronous. Reads are combinational from the address.

Top module: `pwm_brk_ctl`

## Requirements
- R1: After reset, every register reads zero, all four outputs are low and the counter starts at 0.
- R2: The counter advances by one on every clock and wraps from 4095 to 0, so a channel with duty 1 goes high once every 4096 cycles.
- R3: When no stop is active, an enabled channel is high exactly while the counter is below its active duty value. Duty 0 gives a constant low. Duty 4095 gives 4095 high cycles per period.
- R4: A duty value written to a channel replaces the active duty only on the clock where the counter wraps from 4095 to 0. Until then the old duty keeps driving the output.
- R5: A channel whose enable bit is 0 is always low, whether or not a stop is active. The enable bits are at address 1, bit n for channel n.
- R6: Source select is control-register bit 1. A value of 0 watches the stop pin and 1 watches the comparator input. The input that is not selected has no effect on the flag.
- R7: Polarity is control-register bit 2. A value of 0 makes a low input the fault level and 1 makes a high input the fault level.
- R8: Detection enable is control-register bit 0. While it is 0, no input level sets the flag.
- R9: An input that reaches the fault level and holds it sets the flag on the third rising clock edge after the change. The path is a two-stage synchronizer followed by the flag register.
- R10: The stop flag is control-register bit 3. It stays set after the input returns to its idle level. Writing 0 to it clears it, and writing 1 to it sets it with or without detection.
- R11: A software write to the flag takes priority over detection in the same cycle. If the fault level is still present, the flag reads 0 for one cycle and is set again on the next edge.
- R12: While the flag is set, enabled channel n outputs control-register bit 4+n, the pattern field, as a static level.
- R13: Register map: address 0 is control, address 1 is the channel enables, and addresses 2 to 5 are the duty values of channels 0 to 3 in bits 11:0. A read returns the stored value, and bits with no storage read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| brk_pin_i | input | 1 | External stop input (asynchronous) |
| cmp_i | input | 1 | Comparator digital output (asynchronous) |
| pwm_o | output | 4 | Channel outputs, bit n is channel n |

## Verification
A software write to the stop flag and hardware detection can both act on the flag in the same clock. The bench provokes this by holding the stop pin at its fault level and then writing 0 to the flag. The flag must read 0 at the sample after the write edge and 1 at the sample after the following edge. A duty write and a counter wrap can also meet. The bench writes a new duty early in a period and checks that the old width still holds at count 200, and that the new width appears at count 200 of the next period. A behavioural model runs in parallel and every output and read value is compared on each clock.

// File: rtl/pwm_brk_pkg.sv
package pwm_brk_pkg;
   // Control register bit positions
   localparam int CTL_DET_EN  = 0;
   localparam int CTL_SRC     = 1;
   localparam int CTL_POL     = 2;
   localparam int CTL_FLAG    = 3;
   localparam int CTL_PAT_LSB = 4;

   // Register addresses
   localparam int ADR_CTRL  = 0;
   localparam int ADR_OE    = 1;
   localparam int ADR_DUTY0 = 2;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_CMP = 1'b1
   } brk_src_e;

   typedef struct packed {
      logic     det_en;
      brk_src_e src;
      logic     pol;
   } brk_cfg_t;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = (cnt_q == CNT_TOP);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int CNT_W  = 12,
   parameter bit SHADOW = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic             oe_i,
   input  logic             brk_i,
   input  logic             pat_i,
   output logic [CNT_W-1:0] act_o,
   output logic             pwm_o
);
   logic [CNT_W-1:0] act_q;

   generate
      if (SHADOW) begin : g_shadow
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     act_q <= '0;
            else if (load_i) act_q <= duty_i;
         end
      end else begin : g_direct
         logic unused_load;
         assign unused_load = load_i;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) act_q <= '0;
            else         act_q <= duty_i;
         end
      end
   endgenerate

   assign act_o = act_q;
   assign pwm_o = oe_i && (brk_i ? pat_i : (cnt_i < act_q));
endmodule

// File: rtl/brk_detect.sv
module brk_detect
   import pwm_brk_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  brk_cfg_t cfg_i,
   input  logic     pin_s_i,
   input  logic     cmp_s_i,
   input  logic     sw_wr_i,
   input  logic     sw_val_i,
   output logic     flag_o
);
   logic lvl;
   logic hit;
   logic flag_q;

   always_comb begin
      lvl = (cfg_i.src == SRC_CMP) ? cmp_s_i : pin_s_i;
      hit = cfg_i.det_en && (lvl == cfg_i.pol);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q <= 1'b0;
      else if (sw_wr_i) flag_q <= sw_val_i;
      else if (hit)     flag_q <= 1'b1;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/pwm_brk_ctl.sv
module pwm_brk_ctl
   import pwm_brk_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 12,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit SHADOW_DUTY = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              brk_pin_i,
   input  logic              cmp_i,
   output logic [NUM_CH-1:0] pwm_o
);
   localparam int PAT_HI   = CTL_PAT_LSB + NUM_CH;
   localparam int USED_W   = (CNT_W > PAT_HI) ? CNT_W : PAT_HI;
   localparam int NUM_REGS = ADR_DUTY0 + NUM_CH;

   generate
      if (NUM_CH < 1 || PAT_HI > DATA_W) begin : g_bad_ch
         $error("NUM_CH does not fit the control register");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic                         det_en_q;
   brk_src_e                     src_q;
   logic                         pol_q;
   logic [NUM_CH-1:0]            pat_q;
   logic [NUM_CH-1:0]            oe_q;
   logic [NUM_CH-1:0][CNT_W-1:0] duty_q;
   logic [NUM_CH-1:0][CNT_W-1:0] act_duty;
   logic [CNT_W-1:0]             cnt;
   logic                         wrap;
   logic                         brk_flag;
   logic                         pin_s;
   logic                         cmp_s;
   logic                         ctrl_wr;
   brk_cfg_t                     cfg;

   assign ctrl_wr    = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CTRL));
   assign cfg.det_en = det_en_q;
   assign cfg.src    = src_q;
   assign cfg.pol    = pol_q;

   // Configuration registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         det_en_q <= 1'b0;
         src_q    <= SRC_PIN;
         pol_q    <= 1'b0;
         pat_q    <= '0;
         oe_q     <= '0;
         duty_q   <= '0;
      end else if (reg_wr_i) begin
         if (reg_addr_i == ADDR_W'(ADR_CTRL)) begin
            det_en_q <= reg_wdata_i[CTL_DET_EN];
            src_q    <= brk_src_e'(reg_wdata_i[CTL_SRC]);
            pol_q    <= reg_wdata_i[CTL_POL];
            pat_q    <= reg_wdata_i[CTL_PAT_LSB +: NUM_CH];
         end
         if (reg_addr_i == ADDR_W'(ADR_OE)) begin
            oe_q <= reg_wdata_i[NUM_CH-1:0];
         end
         for (int n = 0; n < NUM_CH; n++) begin
            if (reg_addr_i == ADDR_W'(ADR_DUTY0 + n)) begin
               duty_q[n] <= reg_wdata_i[CNT_W-1:0];
            end
         end
      end
   end

   // Read mux
   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == ADDR_W'(ADR_CTRL)) begin
         reg_rdata_o[CTL_DET_EN]            = det_en_q;
         reg_rdata_o[CTL_SRC]               = src_q;
         reg_rdata_o[CTL_POL]               = pol_q;
         reg_rdata_o[CTL_FLAG]              = brk_flag;
         reg_rdata_o[CTL_PAT_LSB +: NUM_CH] = pat_q;
      end
      if (reg_addr_i == ADDR_W'(ADR_OE)) begin
         reg_rdata_o[NUM_CH-1:0] = oe_q;
      end
      for (int n = 0; n < NUM_CH; n++) begin
         if (reg_addr_i == ADDR_W'(ADR_DUTY0 + n)) begin
            reg_rdata_o[CNT_W-1:0] = duty_q[n];
         end
      end
   end

   generate
      if (DATA_W > USED_W) begin : g_unused
         logic unused_wdata;
         assign unused_wdata = ^reg_wdata_i[DATA_W-1:USED_W];
      end
   endgenerate

   brk_sync #(.STAGES(SYNC_STAGES)) u_sync_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (brk_pin_i),
      .q_o    (pin_s)
   );

   brk_sync #(.STAGES(SYNC_STAGES)) u_sync_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cmp_i),
      .q_o    (cmp_s)
   );

   brk_detect u_detect (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_i    (cfg),
      .pin_s_i  (pin_s),
      .cmp_s_i  (cmp_s),
      .sw_wr_i  (ctrl_wr),
      .sw_val_i (reg_wdata_i[CTL_FLAG]),
      .flag_o   (brk_flag)
   );

   pwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_o  (cnt),
      .wrap_o (wrap)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         pwm_chan #(.CNT_W(CNT_W), .SHADOW(SHADOW_DUTY)) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cnt_i  (cnt),
            .load_i (wrap),
            .duty_i (duty_q[g]),
            .oe_i   (oe_q[g]),
            .brk_i  (brk_flag),
            .pat_i  (pat_q[g]),
            .act_o  (act_duty[g]),
            .pwm_o  (pwm_o[g])
         );
      end
   endgenerate
endmodule

// File: rtl/pwm_brk_chk.sv
module pwm_brk_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 12
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [CNT_W-1:0]             cnt,
   input logic [NUM_CH-1:0][CNT_W-1:0] act,
   input logic                         flag,
   input logic                         det_en,
   input logic                         ctrl_wr,
   input logic [NUM_CH-1:0]            oe,
   input logic [NUM_CH-1:0]            pat,
   input logic [NUM_CH-1:0]            pwm
);
   localparam logic [CNT_W-1:0] TOP = '1;

   // R2: counter steps by one below the top value
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != TOP) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R2: counter returns to zero after the top value
   a_r2_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP) |=> (cnt == '0));

   // R10: flag holds unless software writes the control register
   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ctrl_wr) |=> flag);

   // R8: no hardware set while detection is disabled
   a_r8_no_hw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !det_en && !ctrl_wr) |=> !flag);

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         // R4: active duty changes only across a wrap
         a_r4_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != TOP) |=> $stable(act[g]));

         // R5: disabled channel stays low
         a_r5_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
            !oe[g] |-> !pwm[g]);

         // R12: enabled channel shows its pattern bit during a stop
         a_r12_pattern: assert property (@(posedge clk) disable iff (!rst_n)
            (flag && oe[g]) |-> (pwm[g] == pat[g]));
      end
   endgenerate
endmodule

bind pwm_brk_ctl pwm_brk_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk     (clk_i),
   .rst_n   (rst_ni),
   .cnt     (cnt),
   .act     (act_duty),
   .flag    (brk_flag),
   .det_en  (det_en_q),
   .ctrl_wr (ctrl_wr),
   .oe      (oe_q),
   .pat     (pat_q),
   .pwm     (pwm_o)
);

// File: tb/sim_pwm_brk_ctl.sv
`timescale 1ns/1ps
module sim_pwm_brk_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        brk_pin = 1'b1;
   logic        cmp = 1'b0;
   logic [3:0]  pwm;

   int checks = 0;
   int fails = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwm_brk_ctl u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_wr_i    (reg_wr),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .brk_pin_i   (brk_pin),
      .cmp_i       (cmp),
      .pwm_o       (pwm)
   );

   // ---------------- behavioural reference model ----------------
   int m_cnt;
   int m_duty[4];
   int m_act[4];
   bit m_det, m_src, m_pol, m_flag;
   bit [3:0] m_pat, m_oe;
   bit sp1, sp2, sc1, sc2;

   always @(posedge clk or negedge rst_n) begin : model
      bit lvl;
      bit hit;
      if (!rst_n) begin
         m_cnt <= 0;
         for (int n = 0; n < 4; n++) begin
            m_duty[n] <= 0;
            m_act[n]  <= 0;
         end
         m_det <= 0; m_src <= 0; m_pol <= 0; m_flag <= 0;
         m_pat <= 0; m_oe <= 0;
         sp1 <= 0; sp2 <= 0; sc1 <= 0; sc2 <= 0;
      end else begin
         sp1 <= brk_pin; sp2 <= sp1;
         sc1 <= cmp;     sc2 <= sc1;
         lvl = m_src ? sc2 : sp2;
         hit = m_det && (lvl == m_pol);
         if (m_cnt == 4095)
            for (int n = 0; n < 4; n++) m_act[n] <= m_duty[n];
         m_cnt <= (m_cnt + 1) % 4096;
         if (reg_wr && reg_addr == 3'd0) m_flag <= reg_wdata[3];
         else if (hit)                   m_flag <= 1'b1;
         if (reg_wr) begin
            if (reg_addr == 3'd0) begin
               m_det <= reg_wdata[0];
               m_src <= reg_wdata[1];
               m_pol <= reg_wdata[2];
               m_pat <= reg_wdata[7:4];
            end else if (reg_addr == 3'd1) begin
               m_oe <= reg_wdata[3:0];
            end else if (reg_addr >= 3'd2 && reg_addr <= 3'd5) begin
               m_duty[reg_addr - 3'd2] <= int'(reg_wdata[11:0]);
            end
         end
      end
   end

   function automatic bit exp_pwm(int n);
      if (!m_oe[n]) return 1'b0;
      if (m_flag)   return m_pat[n];
      return (m_cnt < m_act[n]);
   endfunction

   function automatic logic [15:0] exp_read(logic [2:0] a);
      logic [15:0] v = 16'd0;
      case (a)
         3'd0: v = {8'd0, m_pat, m_flag, m_pol, m_src, m_det};
         3'd1: v = {12'd0, m_oe};
         3'd2, 3'd3, 3'd4, 3'd5: v = 16'(m_duty[a - 3'd2]);
         default: v = 16'd0;
      endcase
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         for (int n = 0; n < 4; n++) begin
            if (!m_oe[n])                chk("R5 disabled channel", 32'(pwm[n]), 32'(exp_pwm(n)));
            else if (m_flag)             chk("R12 pattern", 32'(pwm[n]), 32'(exp_pwm(n)));
            else if (m_act[n] != m_duty[n]) chk("R4 pending duty", 32'(pwm[n]), 32'(exp_pwm(n)));
            else                         chk("R3 compare", 32'(pwm[n]), 32'(exp_pwm(n)));
         end
         chk("R13 read", 32'(reg_rdata), 32'(exp_read(reg_addr)));
      end
   end

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 16'd0;
   endtask

   task automatic set_pin(logic v);
      @(posedge clk); #1; brk_pin = v;
   endtask

   task automatic set_cmp(logic v);
      @(posedge clk); #1; cmp = v;
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] ctl(bit det, bit src, bit pol, bit flg, logic [3:0] pat);
      return {8'd0, pat, flg, pol, src, det};
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin : main
      int k;
      int h[4];
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      chk("R1 ctrl reset", 32'(reg_rdata), 32'h0);
      chk("R1 outputs reset", 32'(pwm), 32'h0);
      reg_addr = 3'd4;
      @(negedge clk);
      chk("R1 duty reset", 32'(reg_rdata), 32'h0);
      reg_addr = 3'd0;

      // R13: upper write bits are not stored
      wr(3'd3, 16'hFABC);
      reg_addr = 3'd3;
      @(negedge clk);
      chk("R13 duty readback", 32'(reg_rdata), 32'h0ABC);
      reg_addr = 3'd0;

      wr(3'd2, 16'd1);
      wr(3'd3, 16'd0);
      wr(3'd4, 16'd4095);
      wr(3'd5, 16'd100);
      wr(3'd1, 16'h000F);

      // R2: period length
      @(negedge clk);
      while (!pwm[0]) @(negedge clk);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!pwm[0]);
      chk("R2 period", 32'(k), 32'd4096);

      // R3: high cycles over one full period
      for (int n = 0; n < 4; n++) h[n] = 0;
      repeat (4096) begin
         @(negedge clk);
         for (int n = 0; n < 4; n++) if (pwm[n]) h[n]++;
      end
      chk("R3 duty 1", 32'(h[0]), 32'd1);
      chk("R3 duty 0", 32'(h[1]), 32'd0);
      chk("R3 duty 4095", 32'(h[2]), 32'd4095);
      chk("R3 duty 100", 32'(h[3]), 32'd100);

      // R4: new duty waits for the wrap
      wr(3'd5, 16'd4000);
      while (m_cnt != 200) @(negedge clk);
      chk("R4 old duty kept", 32'(pwm[3]), 32'd0);
      @(negedge clk);
      while (m_cnt != 200) @(negedge clk);
      chk("R4 new duty applied", 32'(pwm[3]), 32'd1);

      // R8: detection disabled, pin at low fault level
      wr(3'd0, ctl(0, 0, 0, 0, 4'hA));
      set_pin(1'b0);
      step(6);
      chk("R8 no detect", 32'(reg_rdata[3]), 32'd0);

      // R7: high level is idle under low polarity
      set_pin(1'b1);
      step(4);
      wr(3'd0, ctl(1, 0, 0, 0, 4'hA));
      step(6);
      chk("R7 idle level", 32'(reg_rdata[3]), 32'd0);

      // R9: latency through synchronizer
      set_pin(1'b0);
      step(3);
      chk("R9 not yet", 32'(reg_rdata[3]), 32'd0);
      step(1);
      chk("R9 flag set", 32'(reg_rdata[3]), 32'd1);
      chk("R12 pattern out", 32'(pwm), 32'hA);

      // R10: sticky after input goes idle
      set_pin(1'b1);
      step(6);
      chk("R10 sticky", 32'(reg_rdata[3]), 32'd1);

      // R5: enable mask during stop
      wr(3'd0, ctl(1, 0, 0, 1, 4'hF));
      wr(3'd1, 16'h0005);
      @(negedge clk);
      chk("R5 masked pattern", 32'(pwm), 32'h5);
      wr(3'd1, 16'h000F);

      // R10: software clear
      wr(3'd0, ctl(1, 0, 0, 0, 4'hF));
      @(negedge clk);
      chk("R10 cleared", 32'(reg_rdata[3]), 32'd0);
      step(4);
      chk("R10 stays clear", 32'(reg_rdata[3]), 32'd0);

      // R11: clear while fault present
      set_pin(1'b0);
      step(6);
      chk("R11 set", 32'(reg_rdata[3]), 32'd1);
      wr(3'd0, ctl(1, 0, 0, 0, 4'hF));
      @(negedge clk);
      chk("R11 clear wins", 32'(reg_rdata[3]), 32'd0);
      @(negedge clk);
      chk("R11 reasserted", 32'(reg_rdata[3]), 32'd1);

      // R6: comparator source, high polarity
      wr(3'd0, ctl(1, 1, 1, 0, 4'h0));
      step(6);
      chk("R6 cmp idle", 32'(reg_rdata[3]), 32'd0);
      set_pin(1'b1);
      step(6);
      chk("R6 pin ignored", 32'(reg_rdata[3]), 32'd0);
      set_cmp(1'b1);
      step(4);
      chk("R6 R7 cmp high sets", 32'(reg_rdata[3]), 32'd1);
      chk("R12 zero pattern", 32'(pwm), 32'h0);

      // R10: software set without detection
      set_cmp(1'b0);
      wr(3'd0, ctl(0, 1, 1, 0, 4'h3));
      step(2);
      chk("R10 clear before set", 32'(reg_rdata[3]), 32'd0);
      wr(3'd0, ctl(0, 1, 1, 1, 4'h3));
      @(negedge clk);
      chk("R10 software set", 32'(reg_rdata[3]), 32'd1);
      chk("R12 pattern 3", 32'(pwm), 32'h3);
      step(4);

      finish_run();
   end
endmodule